// File: doc/BRIEF.md
# Four-Channel Complex Weight Beamformer

The block takes four coherent complex sample streams that arrive in lockstep under one shared valid strobe. From them it forms four independent beams at the same time. Each beam is a weighted sum over all four channels, and every product inside it uses its own complex weight. The weights sit in a 4x4 array of complex values. A simple write port fills that array, and each beam output then feeds its own decimation and framing path further downstream.

Weights are signed 16-bit values with 14 fractional bits. A write lands in a shadow copy first. A commit strobe then moves the whole shadow copy into the working array in one cycle, so a sample never sees a mix of old and new weights. After reset the working array holds the identity matrix, and each beam then reproduces one raw channel. Products and sums keep full precision. Only the final result is rounded and saturated back to 16 bits per component.

A two-state controller tracks the weight bank. BANK_SYNCED means the shadow copy equals the working array. BANK_PENDING means writes are waiting for a commit. The transitions are as follows:
- SYNCED stays in SYNCED on a commit or when there is no write.
- SYNCED goes to PENDING on a write without a commit.
- PENDING goes to SYNCED on a commit, with or without a write in the same cycle.
- PENDING stays in PENDING otherwise.

Top module: `bf4_weighted_beamformer`

## Requirements
- R1: Beam b takes the sum over channels c of x_c*w_bc as a complex product: real part x_re*w_re - x_im*w_im, imaginary part x_re*w_im + x_im*w_re, accumulated at full precision. Channel c occupies bits [16c+15:16c] of ch_re/ch_im, and beam b occupies bits [16b+15:16b] of beam_re/beam_im.
- R2: Weights are signed 16-bit values scaled by 2^14, so 16384 means 1.0. After reset every weight w_bc is 16384+j0 when b equals c and 0 otherwise, so beam k repeats channel k exactly.
- R3: The accumulated sum is rounded by adding 2^13 and then shifting arithmetically right by 14. Ties therefore go toward plus infinity: 0.5 becomes 1, -0.5 becomes 0, 1.5 becomes 2 and -1.5 becomes -1.
- R4: A rounded result above 32767 is output as 32767, and a result below -32768 is output as -32768. Real and imaginary parts are clipped separately.
- R5: out_valid goes high exactly three clock edges after the edge that accepts a sample with in_valid high. All four beams of that sample appear together, and back-to-back samples come out back to back.
- R6: After reset, out_valid is low and all beam outputs are zero. Between valid outputs, the beam outputs hold their last value.
- R7: A write with wr_en high changes only the shadow copy. Outputs keep using the working weights until a commit.
- R8: commit copies all 16 shadow weights into the working array at one edge. A sample accepted at that same edge still uses the old weights, and the next sample uses the new ones.
- R9: A write and a commit in the same cycle make the written weight part of the committed set.
- R10: wr_beam selects the beam and wr_chan selects the channel of the weight being written. No other weight changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Shared strobe for the four input samples |
| ch_re | input | 64 | Real parts of channels 0..3, 16 bits each |
| ch_im | input | 64 | Imaginary parts of channels 0..3 |
| wr_en | input | 1 | Write one weight into the shadow copy |
| wr_beam | input | 2 | Beam index of the weight being written |
| wr_chan | input | 2 | Channel index of the weight being written |
| wr_re | input | 16 | Real part of the weight, Q1.14 |
| wr_im | input | 16 | Imaginary part of the weight, Q1.14 |
| commit | input | 1 | Copy the shadow weights to the working array |
| out_valid | output | 1 | Strobe for the four beam outputs |
| beam_re | output | 64 | Real parts of beams 0..3, 16 bits each |
| beam_im | output | 64 | Imaginary parts of beams 0..3 |

## Verification
The bench targets the following corner cases:

- Commit timing at the sample boundary. It sends a sample on the same edge as a commit. A design that applied new weights one edge early would give that sample the new beam and break R8.
- Write and commit in one cycle. A design that dropped the write in this case would leave the weight unchanged.
- Rounding ties. Halves of both signs are driven through a 0.5 weight. A design that truncated, or rounded away from zero, gives a result off by one.
- Saturation. Full-scale inputs are driven with near-2.0 weights on all channels. A design that wrapped instead of clipping shows a sign flip.
- Random streams. Gapped random streams with random weights check the timing of every output and the holding of values between outputs.

// File: rtl/bf4_pkg.sv
package bf4_pkg;
    typedef enum logic [0:0] {
        BANK_SYNCED  = 1'b0,
        BANK_PENDING = 1'b1
    } bank_state_e;
endpackage

// File: rtl/bf4_weight_bank.sv
module bf4_weight_bank
    import bf4_pkg::*;
#(
    parameter int NBM  = 4,
    parameter int NCH  = 4,
    parameter int WW   = 16,
    parameter int FRAC = 14,
    localparam int BIW = $clog2(NBM),
    localparam int CIW = $clog2(NCH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [BIW-1:0]       wr_beam,
    input  logic [CIW-1:0]       wr_chan,
    input  logic signed [WW-1:0] wr_re,
    input  logic signed [WW-1:0] wr_im,
    input  logic                 commit,
    output logic signed [WW-1:0] act_re [NBM][NCH],
    output logic signed [WW-1:0] act_im [NBM][NCH]
);
    localparam int FLATW = NBM * NCH * 2 * WW;
    localparam logic signed [WW-1:0] UNITY = {{(WW-1){1'b0}}, 1'b1} << FRAC;

    bank_state_e state_q, state_d;
    logic        copy_en;

    logic signed [WW-1:0] sh_re  [NBM][NCH];
    logic signed [WW-1:0] sh_im  [NBM][NCH];
    logic signed [WW-1:0] shn_re [NBM][NCH];
    logic signed [WW-1:0] shn_im [NBM][NCH];

    // shadow contents including this cycle's write
    always_comb begin
        shn_re = sh_re;
        shn_im = sh_im;
        if (wr_en) begin
            shn_re[wr_beam][wr_chan] = wr_re;
            shn_im[wr_beam][wr_chan] = wr_im;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BANK_SYNCED;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BANK_SYNCED:  if (wr_en && !commit) state_d = BANK_PENDING;
            BANK_PENDING: if (commit)           state_d = BANK_SYNCED;
            default:                            state_d = BANK_SYNCED;
        endcase
    end

    // controller outputs
    always_comb begin
        copy_en = 1'b0;
        unique case (state_q)
            BANK_SYNCED:  copy_en = commit;
            BANK_PENDING: copy_en = commit;
            default:      copy_en = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NBM; b++) begin
                for (int c = 0; c < NCH; c++) begin
                    sh_re[b][c]  <= (b == c) ? UNITY : '0;
                    sh_im[b][c]  <= '0;
                    act_re[b][c] <= (b == c) ? UNITY : '0;
                    act_im[b][c] <= '0;
                end
            end
        end else begin
            sh_re <= shn_re;
            sh_im <= shn_im;
            if (copy_en) begin
                act_re <= shn_re;
                act_im <= shn_im;
            end
        end
    end

    // flat views for the checks below
    logic [FLATW-1:0] act_flat, sh_flat;
    always_comb begin
        act_flat = '0;
        sh_flat  = '0;
        for (int b = 0; b < NBM; b++) begin
            for (int c = 0; c < NCH; c++) begin
                act_flat[((b*NCH+c)*2)*WW +: WW]   = act_re[b][c];
                act_flat[((b*NCH+c)*2+1)*WW +: WW] = act_im[b][c];
                sh_flat[((b*NCH+c)*2)*WW +: WW]    = sh_re[b][c];
                sh_flat[((b*NCH+c)*2+1)*WW +: WW]  = sh_im[b][c];
            end
        end
    end

    assert_act_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(act_flat));

    assert_synced_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BANK_SYNCED) |-> (act_flat == sh_flat));

    assert_commit_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (state_q == BANK_SYNCED));

endmodule

// File: rtl/bf4_cmac.sv
module bf4_cmac #(
    parameter int DW = 16,
    parameter int WW = 16,
    localparam int MW = DW + WW,
    localparam int PW = MW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic signed [WW-1:0] w_re,
    input  logic signed [WW-1:0] w_im,
    output logic signed [PW-1:0] p_re,
    output logic signed [PW-1:0] p_im
);
    logic signed [MW-1:0] m_rr, m_ii, m_ri, m_ir;
    logic signed [PW-1:0] e_rr, e_ii, e_ri, e_ir;

    always_comb begin
        m_rr = a_re * w_re;
        m_ii = a_im * w_im;
        m_ri = a_re * w_im;
        m_ir = a_im * w_re;
        e_rr = {m_rr[MW-1], m_rr};
        e_ii = {m_ii[MW-1], m_ii};
        e_ri = {m_ri[MW-1], m_ri};
        e_ir = {m_ir[MW-1], m_ir};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_re <= '0;
            p_im <= '0;
        end else if (en) begin
            p_re <= e_rr - e_ii;
            p_im <= e_ri + e_ir;
        end
    end
endmodule

// File: rtl/bf4_beam_sum.sv
module bf4_beam_sum #(
    parameter int NCH = 4,
    parameter int PW  = 33,
    localparam int AW = PW + $clog2(NCH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [PW-1:0] p_re [NCH],
    input  logic signed [PW-1:0] p_im [NCH],
    output logic signed [AW-1:0] s_re,
    output logic signed [AW-1:0] s_im
);
    logic signed [AW-1:0] acc_re, acc_im;

    always_comb begin
        acc_re = '0;
        acc_im = '0;
        for (int c = 0; c < NCH; c++) begin
            acc_re = acc_re + {{(AW-PW){p_re[c][PW-1]}}, p_re[c]};
            acc_im = acc_im + {{(AW-PW){p_im[c][PW-1]}}, p_im[c]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_re <= '0;
            s_im <= '0;
        end else if (en) begin
            s_re <= acc_re;
            s_im <= acc_im;
        end
    end
endmodule

// File: rtl/bf4_round_sat.sv
module bf4_round_sat #(
    parameter int AW   = 35,
    parameter int DW   = 16,
    parameter int FRAC = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [AW-1:0] acc,
    output logic signed [DW-1:0] q
);
    localparam logic signed [AW-1:0] HALF = {{(AW-1){1'b0}}, 1'b1} << (FRAC - 1);
    localparam logic signed [AW-1:0] SMAX = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [AW-1:0] SMIN = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [AW-1:0] shifted;
    logic signed [DW-1:0] clip;

    always_comb begin
        shifted = (acc + HALF) >>> FRAC;
        if (shifted > SMAX)      clip = SMAX[DW-1:0];
        else if (shifted < SMIN) clip = SMIN[DW-1:0];
        else                     clip = shifted[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= clip;
    end

    assert_sat_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (shifted > SMAX)) |=> (q == SMAX[DW-1:0]));

    assert_sat_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (shifted < SMIN)) |=> (q == SMIN[DW-1:0]));
endmodule

// File: rtl/bf4_weighted_beamformer.sv
module bf4_weighted_beamformer #(
    parameter int NCH  = 4,
    parameter int NBM  = 4,
    parameter int DW   = 16,
    parameter int WW   = 16,
    parameter int FRAC = 14,
    localparam int BIW = $clog2(NBM),
    localparam int CIW = $clog2(NCH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [NCH*DW-1:0]  ch_re,
    input  logic [NCH*DW-1:0]  ch_im,
    input  logic               wr_en,
    input  logic [BIW-1:0]     wr_beam,
    input  logic [CIW-1:0]     wr_chan,
    input  logic [WW-1:0]      wr_re,
    input  logic [WW-1:0]      wr_im,
    input  logic               commit,
    output logic               out_valid,
    output logic [NBM*DW-1:0]  beam_re,
    output logic [NBM*DW-1:0]  beam_im
);
    localparam int PW = DW + WW + 1;
    localparam int AW = PW + $clog2(NCH);

    logic signed [WW-1:0] act_re [NBM][NCH];
    logic signed [WW-1:0] act_im [NBM][NCH];

    bf4_weight_bank #(.NBM(NBM), .NCH(NCH), .WW(WW), .FRAC(FRAC)) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_beam (wr_beam),
        .wr_chan (wr_chan),
        .wr_re   (wr_re),
        .wr_im   (wr_im),
        .commit  (commit),
        .act_re  (act_re),
        .act_im  (act_im)
    );

    logic v_prod, v_sum, v_out;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_prod <= 1'b0;
            v_sum  <= 1'b0;
            v_out  <= 1'b0;
        end else begin
            v_prod <= in_valid;
            v_sum  <= v_prod;
            v_out  <= v_sum;
        end
    end
    assign out_valid = v_out;

    logic signed [PW-1:0] prod_re [NBM][NCH];
    logic signed [PW-1:0] prod_im [NBM][NCH];
    logic signed [AW-1:0] sum_re  [NBM];
    logic signed [AW-1:0] sum_im  [NBM];
    logic signed [DW-1:0] bq_re   [NBM];
    logic signed [DW-1:0] bq_im   [NBM];

    for (genvar b = 0; b < NBM; b++) begin : g_beam
        for (genvar c = 0; c < NCH; c++) begin : g_chan
            bf4_cmac #(.DW(DW), .WW(WW)) cmac_i (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (in_valid),
                .a_re  (ch_re[c*DW +: DW]),
                .a_im  (ch_im[c*DW +: DW]),
                .w_re  (act_re[b][c]),
                .w_im  (act_im[b][c]),
                .p_re  (prod_re[b][c]),
                .p_im  (prod_im[b][c])
            );
        end

        bf4_beam_sum #(.NCH(NCH), .PW(PW)) sum_i (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (v_prod),
            .p_re  (prod_re[b]),
            .p_im  (prod_im[b]),
            .s_re  (sum_re[b]),
            .s_im  (sum_im[b])
        );

        bf4_round_sat #(.AW(AW), .DW(DW), .FRAC(FRAC)) rs_re_i (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (v_sum),
            .acc   (sum_re[b]),
            .q     (bq_re[b])
        );

        bf4_round_sat #(.AW(AW), .DW(DW), .FRAC(FRAC)) rs_im_i (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (v_sum),
            .acc   (sum_im[b]),
            .q     (bq_im[b])
        );
    end

    always_comb begin
        for (int b = 0; b < NBM; b++) begin
            beam_re[b*DW +: DW] = bq_re[b];
            beam_im[b*DW +: DW] = bq_im[b];
        end
    end

    assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 out_valid);

    assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##3 !out_valid);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(beam_re) && $stable(beam_im)));
endmodule

// File: tb/bf4_weighted_beamformer_tb_top.sv
module bf4_weighted_beamformer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [63:0] ch_re, ch_im;
    logic        wr_en;
    logic [1:0]  wr_beam, wr_chan;
    logic [15:0] wr_re, wr_im;
    logic        commit;
    logic        out_valid;
    logic [63:0] beam_re, beam_im;

    always #5 clk = ~clk;

    bf4_weighted_beamformer dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ch_re(ch_re), .ch_im(ch_im),
        .wr_en(wr_en), .wr_beam(wr_beam), .wr_chan(wr_chan), .wr_re(wr_re), .wr_im(wr_im),
        .commit(commit), .out_valid(out_valid), .beam_re(beam_re), .beam_im(beam_im)
    );

    int     n_chk = 0;
    int     n_bad = 0;
    longint cyc   = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int sh_re [4][4];
    int sh_im [4][4];
    int ac_re [4][4];
    int ac_im [4][4];

    logic [63:0] q_re  [$];
    logic [63:0] q_im  [$];
    longint      q_cyc [$];
    string       q_tag [$];

    logic [63:0] last_re = '0;
    logic [63:0] last_im = '0;

    function automatic int rnd_round_sat(longint acc);
        longint r;
        r = (acc + 64'sd8192) >>> 14;
        if (r > 32767)  return 32767;
        if (r < -32768) return -32768;
        return int'(r);
    endfunction

    function automatic int rnd16();
        return int'($urandom_range(0, 65535)) - 32768;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit v, input int xr[4], input int xi[4],
                        input bit we, input int wb, input int wc, input int wre, input int wim,
                        input bit cm, input string tag);
        logic [63:0] er, ei;
        @(negedge clk);
        in_valid = v;
        for (int c = 0; c < 4; c++) begin
            ch_re[c*16 +: 16] = 16'(xr[c]);
            ch_im[c*16 +: 16] = 16'(xi[c]);
        end
        wr_en   = we;
        wr_beam = 2'(wb);
        wr_chan = 2'(wc);
        wr_re   = 16'(wre);
        wr_im   = 16'(wim);
        commit  = cm;
        if (v) begin
            for (int b = 0; b < 4; b++) begin
                longint ar = 0;
                longint ai = 0;
                for (int c = 0; c < 4; c++) begin
                    ar += longint'(xr[c]) * ac_re[b][c] - longint'(xi[c]) * ac_im[b][c];
                    ai += longint'(xr[c]) * ac_im[b][c] + longint'(xi[c]) * ac_re[b][c];
                end
                er[b*16 +: 16] = 16'(rnd_round_sat(ar));
                ei[b*16 +: 16] = 16'(rnd_round_sat(ai));
            end
            q_re.push_back(er);
            q_im.push_back(ei);
            q_cyc.push_back(cyc);
            q_tag.push_back(tag);
        end
        if (we) begin
            sh_re[wb][wc] = wre;
            sh_im[wb][wc] = wim;
        end
        if (cm) begin
            ac_re = sh_re;
            ac_im = sh_im;
        end
    endtask

    int z4[4] = '{0, 0, 0, 0};

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, z4, z4, 1'b0, 0, 0, 0, 0, 1'b0, "");
    endtask

    task automatic sample(input int xr[4], input int xi[4], input string tag);
        step(1'b1, xr, xi, 1'b0, 0, 0, 0, 0, 1'b0, tag);
    endtask

    task automatic wr(input int b, input int c, input int re, input int im, input bit cm);
        step(1'b0, z4, z4, 1'b1, b, c, re, im, cm, "");
    endtask

    task automatic rnd_sample(input string tag);
        int xr[4];
        int xi[4];
        for (int c = 0; c < 4; c++) begin
            xr[c] = rnd16();
            xi[c] = rnd16();
        end
        sample(xr, xi, tag);
    endtask

    // output scoreboard
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (out_valid) begin
                if (q_re.size() == 0) begin
                    check(1'b0, "R5", "unexpected out_valid", 64'd1, 64'd0);
                end else begin
                    logic [63:0] er, ei;
                    longint      ec;
                    string       tg;
                    er = q_re.pop_front();
                    ei = q_im.pop_front();
                    ec = q_cyc.pop_front();
                    tg = q_tag.pop_front();
                    check(beam_re === er, tg, "beam_re", beam_re, er);
                    check(beam_im === ei, tg, "beam_im", beam_im, ei);
                    check(cyc == ec + 3, "R5", "latency", 64'(cyc - ec), 64'd3);
                end
                last_re = beam_re;
                last_im = beam_im;
            end else begin
                check((beam_re === last_re) && (beam_im === last_im), "R6", "hold",
                      beam_re, last_re);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "WATCHDOG", "timeout", 64'(cyc), 64'd0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int b = 0; b < 4; b++) begin
            for (int c = 0; c < 4; c++) begin
                sh_re[b][c] = (b == c) ? 16384 : 0;
                sh_im[b][c] = 0;
            end
        end
        ac_re = sh_re;
        ac_im = sh_im;

        rst_n = 1'b0; in_valid = 1'b0; ch_re = '0; ch_im = '0;
        wr_en = 1'b0; wr_beam = '0; wr_chan = '0; wr_re = '0; wr_im = '0; commit = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R6: reset state
        check(out_valid === 1'b0, "R6", "reset out_valid", {63'd0, out_valid}, 64'd0);
        check(beam_re === '0 && beam_im === '0, "R6", "reset beams", beam_re, 64'd0);
        rst_n = 1'b1;

        // R2: identity after reset, beam k repeats channel k
        for (int i = 0; i < 6; i++) rnd_sample("R2");
        idle(4);

        // R7: write without commit must not change outputs
        wr(0, 1, 16384, 0, 1'b0);
        rnd_sample("R7");
        idle(4);

        // R10: after commit beam0 = ch0 + ch1, other beams untouched
        wr(3, 3, 16384, 0, 1'b1);
        rnd_sample("R10");
        idle(4);

        // R8: sample on the commit edge uses old weights, next uses new
        wr(1, 1, 0, 16384, 1'b0);
        begin
            int xr[4];
            int xi[4];
            xr = '{100, 2000, -300, 40};
            xi = '{-5, 700, 8, -9000};
            step(1'b1, xr, xi, 1'b0, 0, 0, 0, 0, 1'b1, "R8");
            sample(xr, xi, "R8");
        end
        idle(4);

        // R9: write and commit together
        wr(2, 2, -16384, 0, 1'b1);
        rnd_sample("R9");
        idle(4);

        // R3: rounding ties through a 0.5 weight on beam3 ch3
        wr(3, 3, 8192, 0, 1'b1);
        begin
            int xr[4];
            int xi[4];
            xi = '{0, 0, 0, 0};
            xr = '{0, 0, 0, 1};   sample(xr, xi, "R3");
            xr = '{0, 0, 0, -1};  sample(xr, xi, "R3");
            xr = '{0, 0, 0, 3};   sample(xr, xi, "R3");
            xr = '{0, 0, 0, -3};  sample(xr, xi, "R3");
        end
        idle(4);

        // R4: saturation with near-2.0 weights on every channel of beam0
        for (int c = 0; c < 4; c++) wr(0, c, 32767, 0, (c == 3));
        begin
            int xr[4];
            int xi[4];
            xi = '{0, 0, 0, 0};
            xr = '{32767, 32767, 32767, 32767};     sample(xr, xi, "R4");
            xr = '{-32768, -32768, -32768, -32768}; sample(xr, xi, "R4");
            xi = '{32767, 32767, 32767, 32767};     sample(xr, xi, "R4");
        end
        idle(4);

        // R1: random weights, gapped random stream (R5 latency on every output)
        for (int b = 0; b < 4; b++) begin
            for (int c = 0; c < 4; c++) begin
                wr(b, c, int'($urandom_range(0, 32768)) - 16384,
                   int'($urandom_range(0, 32768)) - 16384, (b == 3 && c == 3));
            end
        end
        for (int i = 0; i < 80; i++) begin
            if ($urandom_range(0, 9) < 7) rnd_sample("R1");
            else idle(1);
        end

        idle(6);
        for (int i = 0; i < 50 && q_re.size() != 0; i++) idle(1);
        check(q_re.size() == 0, "R5", "missing outputs", 64'(q_re.size()), 64'd0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule